// File: doc/BRIEF.md
# Operate Instruction Unit

This block carries out the register-operate instructions of a 12-bit accumulator machine. An instruction word arrives with a one-cycle `start` strobe together with the current accumulator, link bit and program counter. The block returns the updated values and pulses `done`. Each bit in the low part of the word enables one small micro-operation. Several of these can be set in one word, and they are applied in a fixed order. This lets the bits be combined into new operations. For example, clearing the link and then complementing it sets the link.

There are three kinds of operate word. The first kind changes the accumulator and link through clears, complements, an increment and rotations. The second kind tests the accumulator and link and may skip the next instruction by advancing the program counter. The third kind is the extended arithmetic encoding. It is recognised but not executed: it raises `unsupported` and returns the state unchanged. A word whose major opcode is not the operate opcode is also reported as unsupported and passed through unchanged.

Bit numbering: "word bit k" means `instr[11-k]`, so word bit 0 is the most significant bit.

Top module: `opr_unit`

## Requirements
- R1: `done` is high exactly `STAGES` clock edges after each edge at which `start` is sampled high; `STAGES` defaults to 1. Results register only with a new instruction, so `ac_out`, `link_out`, `pc_out` and `unsupported` hold their values in every cycle in which `done` is low.
- R2: While `rst_n` is low, `done`, `ac_out`, `link_out`, `pc_out` and `unsupported` are all 0.
- R3: When `instr[11:9]` is not 3'b111, the result is `unsupported`=1 with the accumulator, link and program counter unchanged. When `instr[11:9]` is 3'b111 and the word is not the extended encoding, `unsupported`=0.
- R4: The extended encoding is `instr[11:9]`=7 with word bit 3 (`instr[8]`) set and word bit 11 (`instr[0]`) set. It gives `unsupported`=1 and leaves the accumulator, link and program counter unchanged.
- R5: First group (word bit 3 clear). Word bit 4 (`instr[7]`) clears AC and word bit 5 (`instr[6]`) clears the link. Then word bit 6 (`instr[5]`) complements AC and word bit 7 (`instr[4]`) complements the link. So 0o7120 gives link 1, and 0o7240 gives AC 0o7777.
- R6: First group: word bit 11 (`instr[0]`) adds 1 to AC after the complements. A carry out of the top AC bit complements the link.
- R7: First group: word bit 8 (`instr[3]`) rotates the 13-bit value {link, AC} right by one place, and word bit 9 (`instr[2]`) rotates it left by one place. The rotation is the last step.
- R8: First group: word bit 10 (`instr[1]`) makes the selected rotation two places. Word bit 10 alone does nothing. Setting both direction bits gives no rotation.
- R9: In the first group, the clears, complements, increment and rotation apply in that order within one instruction. For example, 0o7041 negates AC, and 0o7241 leaves AC at 0 and complements the link. The program counter is unchanged.
- R10: Second group (word bit 3 set, word bit 11 clear). The skip condition is the OR of the enabled tests: word bit 5 (`instr[6]`) tests AC negative, word bit 6 (`instr[5]`) tests AC zero, and word bit 7 (`instr[4]`) tests link nonzero. A skip sets `pc_out` to `pc_in`+1, wrapping modulo 2^PW; otherwise `pc_out` is `pc_in`.
- R11: Second group: word bit 8 (`instr[3]`) inverts the decision, so the skip happens only when every enabled test is false. With no tests enabled, the instruction always skips.
- R12: Second group: word bit 4 (`instr[7]`) clears AC after the test is evaluated. The link is never changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction strobe |
| instr | input | 12 | Instruction word |
| ac_in | input | DW | Accumulator before the instruction |
| link_in | input | 1 | Link bit before the instruction |
| pc_in | input | PW | Program counter before the instruction |
| done | output | 1 | Result valid pulse |
| ac_out | output | DW | Accumulator after the instruction |
| link_out | output | 1 | Link bit after the instruction |
| pc_out | output | PW | Program counter after the instruction |
| unsupported | output | 1 | Instruction was not executed |

## Verification
With the default single result stage, every result is due on the first rising edge after the edge that samples `start`. `done` and all four result outputs change together at that edge and hold until the next result. The bench reference model updates its expected values at the same edge at which the design samples `start`. The bench compares every output at the following falling edge on every cycle, so a result that arrives a cycle early or late, or that changes while `done` is low, shows up as a mismatch. Directed checks read the outputs at the falling edge right after the capturing edge.

// File: rtl/opr_pkg.sv
package opr_pkg;

   localparam int INSTR_W = 12;

   // word bit k (0 = most significant) maps to instr[INSTR_W-1-k]
   localparam int WB3  = INSTR_W - 1 - 3;
   localparam int WB4  = INSTR_W - 1 - 4;
   localparam int WB5  = INSTR_W - 1 - 5;
   localparam int WB6  = INSTR_W - 1 - 6;
   localparam int WB7  = INSTR_W - 1 - 7;
   localparam int WB8  = INSTR_W - 1 - 8;
   localparam int WB9  = INSTR_W - 1 - 9;
   localparam int WB10 = INSTR_W - 1 - 10;
   localparam int WB11 = INSTR_W - 1 - 11;

   localparam logic [2:0] OP_OPERATE = 3'b111;

   typedef enum logic [1:0] {
      CLS_OTHER = 2'd0,
      CLS_ALTER = 2'd1,
      CLS_TEST  = 2'd2,
      CLS_EXT   = 2'd3
   } opr_class_e;

   typedef struct packed {
      logic zap_ac;
      logic zap_lk;
      logic inv_ac;
      logic inv_lk;
      logic rot_r;
      logic rot_l;
      logic rot_2;
      logic bump;
   } alter_ops_t;

   typedef struct packed {
      logic zap_ac;
      logic on_neg;
      logic on_zero;
      logic on_link;
      logic invert;
   } test_ops_t;

endpackage

// File: rtl/opr_decode.sv
module opr_decode
   import opr_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   output opr_class_e         cls,
   output alter_ops_t         alt,
   output test_ops_t          tst
);

   logic [2:0] major;

   always_comb begin
      major = instr[INSTR_W-1 -: 3];
      if (major != OP_OPERATE)  cls = CLS_OTHER;
      else if (!instr[WB3])     cls = CLS_ALTER;
      else if (!instr[WB11])    cls = CLS_TEST;
      else                      cls = CLS_EXT;
   end

   always_comb begin
      alt.zap_ac = instr[WB4];
      alt.zap_lk = instr[WB5];
      alt.inv_ac = instr[WB6];
      alt.inv_lk = instr[WB7];
      alt.rot_r  = instr[WB8];
      alt.rot_l  = instr[WB9];
      alt.rot_2  = instr[WB10];
      alt.bump   = instr[WB11];
   end

   always_comb begin
      tst.zap_ac  = instr[WB4];
      tst.on_neg  = instr[WB5];
      tst.on_zero = instr[WB6];
      tst.on_link = instr[WB7];
      tst.invert  = instr[WB8];
   end

endmodule

// File: rtl/opr_rotate.sv
module opr_rotate #(
   parameter int W = 13
) (
   input  logic [W-1:0] v,
   input  logic         go_right,
   input  logic         go_left,
   input  logic         double,
   output logic [W-1:0] y
);

   logic [W-1:0] r1, r2, l1, l2;

   for (genvar j = 0; j < W; j++) begin : g_bit
      localparam int JR1 = (j + 1) % W;
      localparam int JR2 = (j + 2) % W;
      localparam int JL1 = (j + W - 1) % W;
      localparam int JL2 = (j + W - 2) % W;
      assign r1[j] = v[JR1];
      assign r2[j] = v[JR2];
      assign l1[j] = v[JL1];
      assign l2[j] = v[JL2];
   end

   always_comb begin
      if (go_right && !go_left)      y = double ? r2 : r1;
      else if (go_left && !go_right) y = double ? l2 : l1;
      else                           y = v;
   end

endmodule

// File: rtl/opr_alter.sv
module opr_alter
   import opr_pkg::*;
#(
   parameter int DW = 12
) (
   input  alter_ops_t    ops,
   input  logic [DW-1:0] ac_i,
   input  logic          lk_i,
   output logic [DW-1:0] ac_o,
   output logic          lk_o
);

   localparam int RW = DW + 1;

   logic [DW-1:0] a_clr, a_inv, a_inc;
   logic          l_clr, l_inv, l_inc;
   logic [DW:0]   sum;
   logic [RW-1:0] rot_y;

   always_comb begin
      a_clr = ops.zap_ac ? '0 : ac_i;
      l_clr = ops.zap_lk ? 1'b0 : lk_i;
      a_inv = ops.inv_ac ? ~a_clr : a_clr;
      l_inv = ops.inv_lk ? ~l_clr : l_clr;
      sum   = {1'b0, a_inv} + {{DW{1'b0}}, 1'b1};
      a_inc = ops.bump ? sum[DW-1:0] : a_inv;
      l_inc = (ops.bump && sum[DW]) ? ~l_inv : l_inv;
   end

   opr_rotate #(.W(RW)) u_rot (
      .v        ({l_inc, a_inc}),
      .go_right (ops.rot_r),
      .go_left  (ops.rot_l),
      .double   (ops.rot_2),
      .y        (rot_y)
   );

   assign ac_o = rot_y[DW-1:0];
   assign lk_o = rot_y[DW];

endmodule

// File: rtl/opr_test.sv
module opr_test
   import opr_pkg::*;
#(
   parameter int DW = 12,
   parameter int PW = 12
) (
   input  test_ops_t     ops,
   input  logic [DW-1:0] ac_i,
   input  logic          lk_i,
   input  logic [PW-1:0] pc_i,
   output logic [DW-1:0] ac_o,
   output logic [PW-1:0] pc_o
);

   logic hit, take;

   always_comb begin
      hit  = (ops.on_neg  && ac_i[DW-1])
           | (ops.on_zero && (ac_i == '0))
           | (ops.on_link && lk_i);
      take = ops.invert ? ~hit : hit;
      pc_o = take ? pc_i + {{(PW-1){1'b0}}, 1'b1} : pc_i;
      ac_o = ops.zap_ac ? '0 : ac_i;
   end

endmodule

// File: rtl/opr_unit.sv
module opr_unit
   import opr_pkg::*;
#(
   parameter int DW     = 12,
   parameter int PW     = 12,
   parameter int STAGES = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [INSTR_W-1:0]  instr,
   input  logic [DW-1:0]       ac_in,
   input  logic                link_in,
   input  logic [PW-1:0]       pc_in,
   output logic                done,
   output logic [DW-1:0]       ac_out,
   output logic                link_out,
   output logic [PW-1:0]       pc_out,
   output logic                unsupported
);

   localparam int LAST = STAGES - 1;

   if (DW < 2) begin : g_bad_dw
      $error("opr_unit: DW must be at least 2");
   end
   if (PW < 1) begin : g_bad_pw
      $error("opr_unit: PW must be at least 1");
   end
   if (STAGES < 1 || STAGES > 2) begin : g_bad_stages
      $error("opr_unit: STAGES must be 1 or 2");
   end

   opr_class_e    cls;
   alter_ops_t    alt;
   test_ops_t     tst;
   logic [DW-1:0] alt_ac, tst_ac, nx_ac;
   logic          alt_lk, nx_lk, nx_uns;
   logic [PW-1:0] tst_pc, nx_pc;

   opr_decode u_dec (
      .instr (instr),
      .cls   (cls),
      .alt   (alt),
      .tst   (tst)
   );

   opr_alter #(.DW(DW)) u_alt (
      .ops  (alt),
      .ac_i (ac_in),
      .lk_i (link_in),
      .ac_o (alt_ac),
      .lk_o (alt_lk)
   );

   opr_test #(.DW(DW), .PW(PW)) u_tst (
      .ops  (tst),
      .ac_i (ac_in),
      .lk_i (link_in),
      .pc_i (pc_in),
      .ac_o (tst_ac),
      .pc_o (tst_pc)
   );

   always_comb begin
      nx_ac  = ac_in;
      nx_lk  = link_in;
      nx_pc  = pc_in;
      nx_uns = 1'b0;
      unique case (cls)
         CLS_ALTER: begin
            nx_ac = alt_ac;
            nx_lk = alt_lk;
         end
         CLS_TEST: begin
            nx_ac = tst_ac;
            nx_pc = tst_pc;
         end
         default: nx_uns = 1'b1;
      endcase
   end

   logic          vq   [STAGES];
   logic [DW-1:0] acq  [STAGES];
   logic          lkq  [STAGES];
   logic [PW-1:0] pcq  [STAGES];
   logic          unq  [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic          v_in, l_in, u_in;
      logic [DW-1:0] a_in;
      logic [PW-1:0] p_in;

      if (s == 0) begin : g_head
         assign v_in = start;
         assign a_in = nx_ac;
         assign l_in = nx_lk;
         assign p_in = nx_pc;
         assign u_in = nx_uns;
      end else begin : g_tail
         assign v_in = vq[s-1];
         assign a_in = acq[s-1];
         assign l_in = lkq[s-1];
         assign p_in = pcq[s-1];
         assign u_in = unq[s-1];
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vq[s]  <= 1'b0;
            acq[s] <= '0;
            lkq[s] <= 1'b0;
            pcq[s] <= '0;
            unq[s] <= 1'b0;
         end else begin
            vq[s] <= v_in;
            if (v_in) begin
               acq[s] <= a_in;
               lkq[s] <= l_in;
               pcq[s] <= p_in;
               unq[s] <= u_in;
            end
         end
      end
   end

   assign done        = vq[LAST];
   assign ac_out      = acq[LAST];
   assign link_out    = lkq[LAST];
   assign pc_out      = pcq[LAST];
   assign unsupported = unq[LAST];

endmodule

// File: rtl/opr_unit_chk.sv
module opr_unit_chk #(
   parameter int DW     = 12,
   parameter int PW     = 12,
   parameter int STAGES = 1
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic [11:0]    instr,
   input logic [DW-1:0]  ac_in,
   input logic           link_in,
   input logic [PW-1:0]  pc_in,
   input logic           done,
   input logic [DW-1:0]  ac_out,
   input logic           link_out,
   input logic [PW-1:0]  pc_out,
   input logic           unsupported
);

   localparam int LAST = STAGES - 1;

   logic          sp [STAGES];
   logic [11:0]   ci [STAGES];
   logic [DW-1:0] ca [STAGES];
   logic          cl [STAGES];
   logic [PW-1:0] cp [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) sp[s] <= 1'b0;
      end else begin
         sp[0] <= start;
         for (int s = 1; s < STAGES; s++) sp[s] <= sp[s-1];
      end
   end

   always_ff @(posedge clk) begin
      if (start) begin
         ci[0] <= instr;
         ca[0] <= ac_in;
         cl[0] <= link_in;
         cp[0] <= pc_in;
      end
      for (int s = 1; s < STAGES; s++) begin
         if (sp[s-1]) begin
            ci[s] <= ci[s-1];
            ca[s] <= ca[s-1];
            cl[s] <= cl[s-1];
            cp[s] <= cp[s-1];
         end
      end
   end

   logic [11:0] w;
   logic        is_op, is_alt, is_tst, is_ext;

   always_comb begin
      w      = ci[LAST];
      is_op  = (w[11:9] == 3'b111);
      is_alt = is_op && !w[8];
      is_tst = is_op && w[8] && !w[0];
      is_ext = is_op && w[8] && w[0];
   end

   p_done_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done == sp[LAST]);

   p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(ac_out) && $stable(link_out) && $stable(pc_out) && $stable(unsupported)));

   p_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (unsupported == (!is_op || is_ext)));

   p_keep_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && unsupported) |-> (ac_out == ca[LAST] && link_out == cl[LAST] && pc_out == cp[LAST]));

   p_set_link_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && is_alt && w[6] && w[4] && !w[0] && !w[3] && !w[2]) |-> link_out);

   p_alter_pc_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && is_alt) |-> (pc_out == cp[LAST]));

   p_skip_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && is_tst) |-> (pc_out == cp[LAST] || pc_out == cp[LAST] + 1'b1));

   p_test_link_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (done && is_tst) |-> (link_out == cl[LAST]));

   p_test_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (done && is_tst && w[7]) |-> (ac_out == '0));

endmodule

bind opr_unit opr_unit_chk #(.DW(DW), .PW(PW), .STAGES(STAGES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .instr       (instr),
   .ac_in       (ac_in),
   .link_in     (link_in),
   .pc_in       (pc_in),
   .done        (done),
   .ac_out      (ac_out),
   .link_out    (link_out),
   .pc_out      (pc_out),
   .unsupported (unsupported)
);

// File: tb/sim_opr_unit.sv
`timescale 1ns/1ps
module sim_opr_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [11:0] instr = '0;
   logic [11:0] ac_in = '0;
   logic        link_in = 1'b0;
   logic [11:0] pc_in = '0;
   logic        done, link_out, unsupported;
   logic [11:0] ac_out, pc_out;

   always #2.5 clk = ~clk;

   opr_unit u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .instr       (instr),
      .ac_in       (ac_in),
      .link_in     (link_in),
      .pc_in       (pc_in),
      .done        (done),
      .ac_out      (ac_out),
      .link_out    (link_out),
      .pc_out      (pc_out),
      .unsupported (unsupported)
   );

   int total = 0;
   int bad   = 0;
   bit running = 1'b0;

   logic        e_done = 1'b0, e_lk = 1'b0, e_un = 1'b0;
   logic [11:0] e_ac = '0, e_pc = '0;
   string       e_tag = "R2";

   function automatic bit wb(input logic [11:0] i, input int k);
      return i[11-k];
   endfunction

   function automatic string classify(input logic [11:0] i);
      if (i[11:9] != 3'd7) return "R3";
      if (!wb(i, 3))       return "R9";
      if (wb(i, 11))       return "R4";
      if (wb(i, 8))        return "R11";
      return "R10";
   endfunction

   // behavioural reference: integers, applied step by step
   function automatic void ref_op(input logic [11:0] i, input int a0, input int l0, input int p0,
                                  output int a, output int l, output int p, output int u);
      int v;
      bit cond;
      a = a0; l = l0; p = p0; u = 0;
      if (i[11:9] != 3'd7 || (wb(i, 3) && wb(i, 11))) begin
         u = 1;
      end else if (!wb(i, 3)) begin
         if (wb(i, 4)) a = 0;
         if (wb(i, 5)) l = 0;
         if (wb(i, 6)) a = 4095 - a;
         if (wb(i, 7)) l = 1 - l;
         if (wb(i, 11)) begin
            a = a + 1;
            if (a == 4096) begin a = 0; l = 1 - l; end
         end
         v = l * 4096 + a;
         for (int n = 0; n < (wb(i, 10) ? 2 : 1); n++) begin
            if (wb(i, 8) && !wb(i, 9)) v = (v / 2) + (v % 2) * 4096;
            if (wb(i, 9) && !wb(i, 8)) v = ((v * 2) % 8192) + (v / 4096);
         end
         a = v % 4096;
         l = v / 4096;
      end else begin
         cond = (wb(i, 5) && a >= 2048) || (wb(i, 6) && a == 0) || (wb(i, 7) && l == 1);
         if (wb(i, 8) ? !cond : cond) p = (p + 1) % 4096;
         if (wb(i, 4)) a = 0;
      end
   endfunction

   always @(posedge clk) begin
      int a, l, p, u;
      if (!rst_n) begin
         e_done <= 1'b0; e_ac <= '0; e_lk <= 1'b0; e_pc <= '0; e_un <= 1'b0;
      end else if (start) begin
         ref_op(instr, int'(ac_in), int'(link_in), int'(pc_in), a, l, p, u);
         e_done <= 1'b1;
         e_ac   <= a[11:0];
         e_lk   <= l[0];
         e_pc   <= p[11:0];
         e_un   <= u[0];
         e_tag  <= classify(instr);
      end else begin
         e_done <= 1'b0;
      end
   end

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0o expected=%0o", tag, what, act, exp);
      end
   endtask

   // per-cycle comparison against the model (R1 hold when no result)
   always @(negedge clk) begin
      if (running) begin
         chk("R1", "done", 32'(done), 32'(e_done));
         chk(e_done ? e_tag : "R1", "ac",   32'(ac_out),      32'(e_ac));
         chk(e_done ? e_tag : "R1", "link", 32'(link_out),    32'(e_lk));
         chk(e_done ? e_tag : "R1", "pc",   32'(pc_out),      32'(e_pc));
         chk(e_done ? e_tag : "R1", "uns",  32'(unsupported), 32'(e_un));
      end
   end

   task automatic op(input logic [11:0] i, input logic [11:0] a, input logic l, input logic [11:0] p);
      @(negedge clk);
      start = 1'b1; instr = i; ac_in = a; link_in = l; pc_in = p;
      @(negedge clk);
      start = 1'b0;
   endtask

   initial begin
      #(200000 * 5.0);
      total++; bad++;
      $display("FAIL watchdog run did not finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [15:0] lf = 16'hACE1;
      repeat (3) @(negedge clk);
      chk("R2", "done", 32'(done), 0);
      chk("R2", "ac",   32'(ac_out), 0);
      chk("R2", "pc",   32'(pc_out), 0);
      chk("R2", "uns",  32'(unsupported), 0);
      rst_n = 1'b1;
      running = 1'b1;

      op(12'o7120, 12'o1234, 1'b0, 12'o100); chk("R5", "set link", 32'(link_out), 1);
      op(12'o7120, 12'o1234, 1'b1, 12'o100); chk("R5", "set link", 32'(link_out), 1);
      op(12'o7240, 12'o1234, 1'b0, 12'o100); chk("R5", "ac ones", 32'(ac_out), 32'o7777);
      op(12'o7001, 12'o7777, 1'b0, 12'o100); chk("R6", "carry ac", 32'(ac_out), 0);
                                             chk("R6", "carry link", 32'(link_out), 1);
      op(12'o7010, 12'o0001, 1'b0, 12'o100); chk("R7", "rar ac", 32'(ac_out), 0);
                                             chk("R7", "rar link", 32'(link_out), 1);
      op(12'o7004, 12'o4000, 1'b0, 12'o100); chk("R7", "ral link", 32'(link_out), 1);
      op(12'o7012, 12'o0001, 1'b0, 12'o100); chk("R8", "rtr ac", 32'(ac_out), 32'o4000);
      op(12'o7002, 12'o1234, 1'b1, 12'o100); chk("R8", "twice alone", 32'(ac_out), 32'o1234);
      op(12'o7014, 12'o1234, 1'b1, 12'o100); chk("R8", "both dirs", 32'(ac_out), 32'o1234);
      op(12'o7041, 12'o0005, 1'b0, 12'o100); chk("R9", "negate", 32'(ac_out), 32'o7773);
      op(12'o7241, 12'o1111, 1'b1, 12'o100); chk("R9", "cla cma iac link", 32'(link_out), 0);
                                             chk("R9", "pc kept", 32'(pc_out), 32'o100);
      op(12'o7500, 12'o4000, 1'b0, 12'o100); chk("R10", "sma skip", 32'(pc_out), 32'o101);
      op(12'o7440, 12'o0000, 1'b0, 12'o7777); chk("R10", "pc wrap", 32'(pc_out), 0);
      op(12'o7420, 12'o0000, 1'b0, 12'o200); chk("R10", "snl no skip", 32'(pc_out), 32'o200);
      op(12'o7410, 12'o0003, 1'b0, 12'o200); chk("R11", "always skip", 32'(pc_out), 32'o201);
      op(12'o7510, 12'o4000, 1'b0, 12'o200); chk("R11", "rev no skip", 32'(pc_out), 32'o200);
      op(12'o7640, 12'o0000, 1'b1, 12'o300); chk("R12", "skip before clear", 32'(pc_out), 32'o301);
      op(12'o7600, 12'o0567, 1'b1, 12'o300); chk("R12", "clear after", 32'(ac_out), 0);
                                             chk("R12", "link kept", 32'(link_out), 1);
      op(12'o5123, 12'o0246, 1'b1, 12'o400); chk("R3", "other opcode", 32'(unsupported), 1);
                                             chk("R3", "ac kept", 32'(ac_out), 32'o246);
      op(12'o7401, 12'o0246, 1'b0, 12'o400); chk("R4", "ext flag", 32'(unsupported), 1);
                                             chk("R4", "pc kept", 32'(pc_out), 32'o400);

      // sweep every operate word with varied state, spaced
      for (int n = 0; n < 512; n++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         op(12'o7000 | 12'(n), lf[11:0], lf[12], {lf[3:0], lf[15:8]});
      end
      // back-to-back starts including other opcodes
      for (int n = 0; n < 600; n++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         @(negedge clk);
         start = lf[0] | lf[1];
         instr = (n % 5 == 0) ? {lf[15:13], lf[8:0]} : {3'b111, lf[14:6]};
         ac_in = (n % 7 == 0) ? 12'o7777 : {lf[5:0], lf[15:10]};
         link_in = lf[9];
         pc_in = (n % 11 == 0) ? 12'o7777 : lf[11:0];
      end
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      running = 1'b0;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule